// File: doc/BRIEF.md
# Serial Interrupt Status and Mask Front End

This block collects seventeen level-sensitive device interrupt lines on the host side of a low-pin-count bus controller. Each line passes through a two-flop synchroniser and an edge detector. A rising level latches a sticky status bit. Firmware masks the status through a register, and an enable bit in a control register gates it. The result is a registered 17-bit active vector that a downstream interrupt router consumes.

Clearing is tied to the input level. A write-one-to-clear removes a status bit only when its synchronised input is already low, so a device that still asserts its line cannot lose its pending state. When the auto-clear control bit is set and the `routed_mode_i` strap selects routed operation, a falling input clears its status bit without any write. A 32-bit register port also holds a firmware segment select word and a read access size word, and it exposes a read-only error address word.

Top module: `sirq_stat_ctrl`

## Requirements
- R1: Register offsets are 0x24 segment select (read/write), 0x28 read access size (read/write), 0x30 control (read/write), 0x34 mask (read/write), 0x38 status and 0x40 error address. A read of any other offset returns 0xFFFFFFFF. Read data is combinational from `reg_addr_i`.
- R2: A rising level on `irq_i[n]` sets status bit 31-n within three clock edges. A bit stays set while the line stays high, and status bits 14:0 always read as zero.
- R3: A write to 0x38 clears status bit 31-n only when that written bit is 1 and the synchronised `irq_i[n]` is low. Written zeros, and bits whose input is high, keep their state. A write never sets a status bit.
- R4: When control bit 23 is 1 and `routed_mode_i` is 1, a falling `irq_i[n]` clears status bit 31-n within three clock edges.
- R5: When control bit 23 is 0 or `routed_mode_i` is 0, a falling input leaves its status bit set.
- R6: `active_o[n]` equals status bit 31-n AND mask bit 31-n while control bit 31 is 1, and is 0 while control bit 31 is 0. It is registered and follows the current state one clock edge later.
- R7: After reset, the read access size word reads 0x02000000. Segment select, control, mask, status, error address and `active_o` read as zero.
- R8: Writes to the error address offset 0x40 are ignored, and that word keeps reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 17 | Device interrupt levels, line n at index n |
| routed_mode_i | input | 1 | Strap that selects routed operation, which allows auto-clear |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| active_o | output | 17 | Masked, enabled interrupt vector |

## Verification
A status bit that is wrongly set or lost shows up at `active_o` one edge after the error, if the line is masked in and enabled. Otherwise it shows up on the next status read, so the bench reads status after every stimulus step. A clear that ignores the input level, or an auto-clear that fires outside routed mode, leaves status and `active_o` different from the bench model within three to four edges of the write or the falling edge. A wrong bit mapping appears as a mismatch in the status word on its first read.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam logic [7:0] OFS_SEG = 8'h24;
  localparam logic [7:0] OFS_RSZ = 8'h28;
  localparam logic [7:0] OFS_CTL = 8'h30;
  localparam logic [7:0] OFS_MSK = 8'h34;
  localparam logic [7:0] OFS_STS = 8'h38;
  localparam logic [7:0] OFS_ERR = 8'h40;
  localparam int unsigned CTL_EN_BIT   = 31;
  localparam int unsigned CTL_AUTO_BIT = 23;
  localparam logic [31:0] RSZ_RESET = 32'h0200_0000;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] lvl_i,
  input  logic         auto_clr_i,
  input  logic         wr_clr_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (wr_clr_i) status_d = status_d & ~(clr_bits_i & ~lvl_i);
    if (auto_clr_i) status_d = status_d & ~fall_i;
    status_d = status_d | rise_i;  // a new edge wins over any clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int unsigned N  = 17,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  status_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output logic          auto_o,
  output logic [N-1:0]  mask_o,
  output logic          sts_wr_o,
  output logic [N-1:0]  sts_bits_o
);
  logic [DW-1:0] seg_q, rsz_q, ctl_q, msk_q;
  logic [DW-1:0] sts_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      rsz_q <= DW'(RSZ_RESET);
      ctl_q <= '0;
      msk_q <= '0;
    end else if (wr_i) begin
      if (addr_i == AW'(OFS_SEG)) seg_q <= wdata_i;
      if (addr_i == AW'(OFS_RSZ)) rsz_q <= wdata_i;
      if (addr_i == AW'(OFS_CTL)) ctl_q <= wdata_i;
      if (addr_i == AW'(OFS_MSK)) msk_q <= wdata_i;
    end
  end

  // line n sits at word bit DW-1-n
  for (genvar n = 0; n < N; n++) begin : g_map
    assign mask_o[n]     = msk_q[DW-1-n];
    assign sts_bits_o[n] = wdata_i[DW-1-n];
  end

  always_comb begin
    sts_word = '0;
    for (int n = 0; n < N; n++) sts_word[DW-1-n] = status_i[n];
  end

  always_comb begin
    if      (addr_i == AW'(OFS_SEG)) rdata_o = seg_q;
    else if (addr_i == AW'(OFS_RSZ)) rdata_o = rsz_q;
    else if (addr_i == AW'(OFS_CTL)) rdata_o = ctl_q;
    else if (addr_i == AW'(OFS_MSK)) rdata_o = msk_q;
    else if (addr_i == AW'(OFS_STS)) rdata_o = sts_word;
    else if (addr_i == AW'(OFS_ERR)) rdata_o = '0;
    else                             rdata_o = '1;
  end

  assign en_o     = ctl_q[CTL_EN_BIT];
  assign auto_o   = ctl_q[CTL_AUTO_BIT];
  assign sts_wr_o = wr_i && (addr_i == AW'(OFS_STS));
endmodule

// File: rtl/sirq_stat_ctrl.sv
module sirq_stat_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned N_IRQ = 17,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             routed_mode_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic [N_IRQ-1:0] active_o
);
  logic [N_IRQ-1:0] lvl_w, rise_w, fall_w, status_w, mask_w, sts_bits_w;
  logic             en_w, auto_w, sts_wr_w, auto_clr_w;
  logic [N_IRQ-1:0] active_q;

  sirq_sync #(.N(N_IRQ)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (irq_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign auto_clr_w = auto_w & routed_mode_i;

  sirq_status #(.N(N_IRQ)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .lvl_i      (lvl_w),
    .auto_clr_i (auto_clr_w),
    .wr_clr_i   (sts_wr_w),
    .clr_bits_i (sts_bits_w),
    .status_o   (status_w)
  );

  sirq_regs #(.N(N_IRQ), .DW(DW), .AW(AW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .status_i   (status_w),
    .rdata_o    (reg_rdata_o),
    .en_o       (en_w),
    .auto_o     (auto_w),
    .mask_o     (mask_w),
    .sts_wr_o   (sts_wr_w),
    .sts_bits_o (sts_bits_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= '0;
    else         active_q <= en_w ? (status_w & mask_w) : '0;
  end

  assign active_o = active_q;
endmodule

// File: rtl/sirq_stat_ctrl_chk.sv
module sirq_stat_ctrl_chk #(
  parameter int unsigned N_IRQ = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IRQ-1:0] lvl_i,
  input logic [N_IRQ-1:0] rise_i,
  input logic [N_IRQ-1:0] fall_i,
  input logic [N_IRQ-1:0] status_i,
  input logic [N_IRQ-1:0] mask_i,
  input logic             en_i,
  input logic             auto_i,
  input logic             routed_i,
  input logic             sts_wr_i,
  input logic [N_IRQ-1:0] active_i
);
  a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((status_i & $past(rise_i)) == $past(rise_i)));

  a_r3_clear_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i |=> (($past(status_i) & $past(lvl_i) & ~status_i) == '0));

  a_r3_write_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && rise_i == '0) |=> ((status_i & ~$past(status_i)) == '0));

  a_r4_auto_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i != '0 && auto_i && routed_i) |=> ((status_i & $past(fall_i)) == '0));

  a_r5_fall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i != '0 && !(auto_i && routed_i) && !sts_wr_i)
      |=> (($past(status_i & fall_i) & ~status_i) == '0));

  a_r6_active_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (active_i == ($past(en_i) ? $past(status_i & mask_i) : '0)));
endmodule

bind sirq_stat_ctrl sirq_stat_ctrl_chk #(.N_IRQ(N_IRQ)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lvl_i    (lvl_w),
  .rise_i   (rise_w),
  .fall_i   (fall_w),
  .status_i (status_w),
  .mask_i   (mask_w),
  .en_i     (en_w),
  .auto_i   (auto_w),
  .routed_i (routed_mode_i),
  .sts_wr_i (sts_wr_w),
  .active_i (active_o)
);

// File: tb/test_sirq_stat_ctrl.sv
module test_sirq_stat_ctrl;
  localparam int N = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          routed = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  active;

  int n_chk = 0;
  int n_fail = 0;

  logic [N-1:0] exp_sts = '0;
  logic [N-1:0] lvl = '0;
  logic [31:0]  ctl = '0;
  logic [31:0]  msk = '0;

  always #5 clk = ~clk;

  sirq_stat_ctrl i_sirq_stat_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .irq_i         (irq),
    .routed_mode_i (routed),
    .reg_wr_i      (wr),
    .reg_addr_i    (addr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .active_o      (active)
  );

  function automatic logic [31:0] to_word(logic [N-1:0] v);
    logic [31:0] w = '0;
    for (int n = 0; n < N; n++) w[31-n] = v[n];
    return w;
  endfunction

  function automatic logic [N-1:0] from_word(logic [31:0] w);
    logic [N-1:0] v;
    for (int n = 0; n < N; n++) v[n] = w[31-n];
    return v;
  endfunction

  function automatic logic [N-1:0] exp_active();
    return ctl[31] ? (exp_sts & from_word(msk)) : '0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a == 8'h30) ctl = d;
    if (a == 8'h34) msk = d;
    if (a == 8'h38) exp_sts = exp_sts & ~(from_word(d) & ~lvl);
    wait_cyc(2);
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_irq(logic [N-1:0] v);
    @(negedge clk);
    irq = v;
    wait_cyc(6);
    exp_sts = exp_sts | (v & ~lvl);
    if (ctl[23] && routed) exp_sts = exp_sts & ~(~v & lvl);
    lvl = v;
  endtask

  task automatic check_state(string req);
    logic [31:0] d;
    reg_read(8'h38, d);
    chk(req, d, to_word(exp_sts));
    chk(req, 32'(active), 32'(exp_active()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R7 reset values, R1 unmapped reads
    reg_read(8'h24, d); chk("R7 seg", d, 32'h0);
    reg_read(8'h28, d); chk("R7 rsz", d, 32'h0200_0000);
    reg_read(8'h30, d); chk("R7 ctl", d, 32'h0);
    reg_read(8'h34, d); chk("R7 msk", d, 32'h0);
    reg_read(8'h38, d); chk("R7 sts", d, 32'h0);
    reg_read(8'h40, d); chk("R7 err", d, 32'h0);
    chk("R7 active", 32'(active), 32'h0);
    reg_read(8'h3c, d); chk("R1 unmapped", d, 32'hffff_ffff);
    reg_read(8'h00, d); chk("R1 unmapped0", d, 32'hffff_ffff);

    // R1 read/write words, R8 error address
    reg_write(8'h24, 32'h1234_5678); reg_read(8'h24, d); chk("R1 seg", d, 32'h1234_5678);
    reg_write(8'h28, 32'h0700_0000); reg_read(8'h28, d); chk("R1 rsz", d, 32'h0700_0000);
    reg_write(8'h40, 32'hdead_beef); reg_read(8'h40, d); chk("R8 err", d, 32'h0);

    // R2 / R6 directed
    reg_write(8'h30, 32'h8000_0000);
    reg_write(8'h34, 32'hffff_8000);
    set_irq(17'h00001);
    reg_read(8'h38, d); chk("R2 irq0 bit31", d, 32'h8000_0000);
    chk("R6 active0", 32'(active), 32'h1);
    set_irq(17'h10001);
    reg_read(8'h38, d); chk("R2 irq16 bit15", d, 32'h8000_8000);
    // R3 input still high: no clear
    reg_write(8'h38, 32'hffff_ffff);
    reg_read(8'h38, d); chk("R3 high holds", d, 32'h8000_8000);
    // R5 fall without auto-clear keeps status
    set_irq(17'h10000);
    reg_read(8'h38, d); chk("R5 fall holds", d, 32'h8000_8000);
    // R3 written zero keeps, written one clears
    reg_write(8'h38, 32'h0000_8000);
    reg_read(8'h38, d); chk("R3 zero keeps", d, 32'h8000_8000);
    reg_write(8'h38, 32'h8000_0000);
    reg_read(8'h38, d); chk("R3 clears low", d, 32'h0000_8000);
    // R5 auto-clear bit set, not routed
    reg_write(8'h30, 32'h8080_0000);
    set_irq(17'h00000);
    reg_read(8'h38, d); chk("R5 not routed", d, 32'h0000_8000);
    // R4 routed auto-clear
    routed = 1'b1;
    set_irq(17'h00004);
    reg_read(8'h38, d); chk("R2 irq2", d, 32'h2000_8000);
    set_irq(17'h00000);
    reg_read(8'h38, d); chk("R4 auto clear", d, 32'h0000_8000);
    // R6 mask and enable gating
    reg_write(8'h34, 32'h0);
    chk("R6 masked", 32'(active), 32'h0);
    reg_write(8'h34, 32'hffff_8000);
    chk("R6 unmasked", 32'(active), 32'h10000);
    reg_write(8'h30, 32'h0);
    chk("R6 disabled", 32'(active), 32'h0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        logic [31:0] c = $urandom;
        reg_write(8'h30, c);
        reg_read(8'h30, d); chk("R1 ctl rb", d, c);
      end
      if ($urandom_range(0, 2) == 0) reg_write(8'h34, $urandom);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); routed = 1'($urandom);
      end
      set_irq(N'($urandom));
      check_state("R2 R4 R5 R6 random");
      if ($urandom_range(0, 1) == 0) begin
        reg_write(8'h38, $urandom);
        check_state("R3 random clear");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule